// File: doc/BRIEF.md
# Half-Step Staggered Integer Adder

This block adds two 32-bit integers on a clock that runs at twice the core rate. It does the work as two 16-bit slices in consecutive fast cycles. The lower slice is added in the first fast cycle, and its carry is registered. The upper slice is added in the second fast cycle, taking that registered carry in. The lower half of a sum is therefore visible one fast cycle after issue, and the whole sum is visible two fast cycles after issue, which is one core cycle.

Each operand has its own forward-select. When a select is set, that operand is taken from the most recent operation rather than from the issue port. The lower half of the operand comes from the previous operation's low result during the first slice. The upper half comes from the previous operation's high result during the second slice. Because of this, a chain of dependent adds can issue on every fast cycle without stalls. It behaves exactly like a chain of single-cycle 32-bit adds.

Top module: `halfstep_adder`

## Requirements
- R1: While reset is held and on the first cycle after it, lo_vld and hi_vld are 0, and lo_res, hi_res and hi_cout are 0.
- R2: Suppose an operation is accepted on a clock edge (iss_vld=1). After the next edge lo_vld=1 and lo_res holds bits 15:0 of the sum of the two operands. lo_vld is 0 after any edge on which no operation was accepted.
- R3: Two edges after the accepting edge, hi_vld=1 and hi_res holds bits 31:16 of the full 32-bit sum, including the carry out of bit 15.
- R4: hi_cout carries the carry out of bit 31 of the same sum, and it updates together with hi_res.
- R5: With iss_fwd_a=1, operand A is the full 32-bit sum of the most recently accepted operation, in place of iss_a.
- R6: With iss_fwd_b=1, operand B is the full 32-bit sum of the most recently accepted operation, in place of iss_b. Both selects may be set together.
- R7: An operation can be accepted on every clock edge with no stall. A back-to-back dependent chain produces the same values as a single-cycle 32-bit reference.
- R8: lo_res keeps its value across an edge with no accepted operation. hi_res and hi_cout keep their values across an edge with no second-slice work.
- R9: After one or more idle cycles, forwarding still refers to the most recently accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (double-rate) clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | Operation accepted on this edge |
| iss_a | input | 32 | Operand A from the issue port |
| iss_b | input | 32 | Operand B from the issue port |
| iss_fwd_a | input | 1 | Take operand A from the previous result |
| iss_fwd_b | input | 1 | Take operand B from the previous result |
| lo_vld | output | 1 | Low half of a result produced by the last edge |
| lo_res | output | 16 | Low half of the sum |
| hi_vld | output | 1 | High half of a result produced by the last edge |
| hi_res | output | 16 | High half of the sum |
| hi_cout | output | 1 | Carry out of bit 31, aligned with hi_res |

## Verification
The bench builds the block with its default 16-bit slice and the behavioural slice adder. That makes carries across bit 15 and out of bit 31 easy to provoke with small constants such as 0x0000FFFF+1 and 0xFFFFFFFF+1. Dependent chains that forward A, B or both on consecutive cycles, and again after idle gaps, are compared with a 32-bit model kept in the bench. The check looks at both result halves on the cycle each should appear.

// File: rtl/halfstep_pkg.sv
package halfstep_pkg;
   // Default slice width; a full word is always two slices.
   localparam int unsigned DEF_HALF_W = 16;
   localparam int unsigned SLICES     = 2;
endpackage

// File: rtl/hs_slice_add.sv
// One bit-slice adder with carry in and carry out; combinational.
module hs_slice_add #(
   parameter int unsigned W          = 16,
   parameter bit          USE_RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   generate
      if (USE_RIPPLE) begin : g_ripple
         logic [W:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]   = a[i] ^ b[i] ^ c[i];
            assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
         end
         assign cout = c[W];
      end else begin : g_behav
         logic [W:0] wide;
         assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
         assign sum  = wide[W-1:0];
         assign cout = wide[W];
      end
   endgenerate
endmodule

// File: rtl/hs_op_select.sv
// Picks a slice operand from the issue port or from the last result.
module hs_op_select #(
   parameter int unsigned W = 16
) (
   input  logic         use_fwd,
   input  logic [W-1:0] own,
   input  logic [W-1:0] fwd,
   output logic [W-1:0] op
);
   assign op = use_fwd ? fwd : own;
endmodule

// File: rtl/halfstep_adder.sv
module halfstep_adder
   import halfstep_pkg::*;
#(
   parameter int unsigned HALF_W     = DEF_HALF_W,
   parameter bit          USE_RIPPLE = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                iss_vld,
   input  logic [2*HALF_W-1:0] iss_a,
   input  logic [2*HALF_W-1:0] iss_b,
   input  logic                iss_fwd_a,
   input  logic                iss_fwd_b,
   output logic                lo_vld,
   output logic [HALF_W-1:0]   lo_res,
   output logic                hi_vld,
   output logic [HALF_W-1:0]   hi_res,
   output logic                hi_cout
);
   localparam int unsigned WORD_W = SLICES * HALF_W;

   generate
      if (HALF_W < 2) begin : g_bad_width
         $error("halfstep_adder: HALF_W must be at least 2");
      end
   endgenerate

   // ---------------- slice 1: low half ----------------
   logic [HALF_W-1:0] s1_a, s1_b, s1_sum;
   logic              s1_c;

   hs_op_select #(.W(HALF_W)) u_sel_alo (
      .use_fwd(iss_fwd_a), .own(iss_a[HALF_W-1:0]), .fwd(lo_res), .op(s1_a));
   hs_op_select #(.W(HALF_W)) u_sel_blo (
      .use_fwd(iss_fwd_b), .own(iss_b[HALF_W-1:0]), .fwd(lo_res), .op(s1_b));

   hs_slice_add #(.W(HALF_W), .USE_RIPPLE(USE_RIPPLE)) u_add_lo (
      .a(s1_a), .b(s1_b), .cin(1'b0), .sum(s1_sum), .cout(s1_c));

   logic [HALF_W-1:0] ahi_q, bhi_q;
   logic              fa_q, fb_q, c_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_vld <= 1'b0;
         lo_res <= '0;
         c_q    <= 1'b0;
         ahi_q  <= '0;
         bhi_q  <= '0;
         fa_q   <= 1'b0;
         fb_q   <= 1'b0;
      end else begin
         lo_vld <= iss_vld;
         if (iss_vld) begin
            lo_res <= s1_sum;
            c_q    <= s1_c;
            ahi_q  <= iss_a[WORD_W-1:HALF_W];
            bhi_q  <= iss_b[WORD_W-1:HALF_W];
            fa_q   <= iss_fwd_a;
            fb_q   <= iss_fwd_b;
         end
      end
   end

   // ---------------- slice 2: high half ----------------
   logic [HALF_W-1:0] s2_a, s2_b, s2_sum;
   logic              s2_c;

   hs_op_select #(.W(HALF_W)) u_sel_ahi (
      .use_fwd(fa_q), .own(ahi_q), .fwd(hi_res), .op(s2_a));
   hs_op_select #(.W(HALF_W)) u_sel_bhi (
      .use_fwd(fb_q), .own(bhi_q), .fwd(hi_res), .op(s2_b));

   hs_slice_add #(.W(HALF_W), .USE_RIPPLE(USE_RIPPLE)) u_add_hi (
      .a(s2_a), .b(s2_b), .cin(c_q), .sum(s2_sum), .cout(s2_c));

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_vld  <= 1'b0;
         hi_res  <= '0;
         hi_cout <= 1'b0;
      end else begin
         hi_vld <= lo_vld;
         if (lo_vld) begin
            hi_res  <= s2_sum;
            hi_cout <= s2_c;
         end
      end
   end

   // ---------------- assertions ----------------
   // R2
   lo_follows_issue_chk: assert property (@(posedge clk) disable iff (rst)
      iss_vld |=> lo_vld);
   // R2
   lo_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !iss_vld |=> !lo_vld);
   // R3
   hi_follows_lo_chk: assert property (@(posedge clk) disable iff (rst)
      lo_vld |=> hi_vld);
   // R8
   lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !iss_vld |=> $stable(lo_res));
   // R8
   hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !lo_vld |=> ($stable(hi_res) && $stable(hi_cout)));
endmodule

// File: tb/sim_halfstep_adder.sv
`timescale 1ns/1ps
module sim_halfstep_adder;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        iss_vld = 1'b0;
   logic [31:0] iss_a = '0, iss_b = '0;
   logic        iss_fwd_a = 1'b0, iss_fwd_b = 1'b0;
   logic        lo_vld, hi_vld, hi_cout;
   logic [15:0] lo_res, hi_res;

   always #2.5 clk = ~clk;   // 200 MHz

   halfstep_adder u0 (
      .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_a(iss_a), .iss_b(iss_b),
      .iss_fwd_a(iss_fwd_a), .iss_fwd_b(iss_fwd_b),
      .lo_vld(lo_vld), .lo_res(lo_res), .hi_vld(hi_vld), .hi_res(hi_res),
      .hi_cout(hi_cout));

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference model state
   logic [31:0] last_sum = '0;
   logic        p1_v = 0, p2_v = 0;
   logic [32:0] p1_s = '0, p2_s = '0;
   logic [15:0] held_lo = '0, held_hi = '0;
   logic        held_c = 0;

   task automatic chk(string req, logic [32:0] act, logic [32:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Check outputs for the current cycle, then drive the next operation.
   task automatic step(bit v, logic [31:0] a, logic [31:0] b, bit fa, bit fb);
      logic [31:0] ea, eb;
      @(negedge clk);
      chk("R2 lo_vld", {32'd0, lo_vld}, {32'd0, p1_v});
      if (p1_v) held_lo = p1_s[15:0];
      chk("R2/R8 lo_res", {17'd0, lo_res}, {17'd0, held_lo});
      chk("R3 hi_vld", {32'd0, hi_vld}, {32'd0, p2_v});
      if (p2_v) begin held_hi = p2_s[31:16]; held_c = p2_s[32]; end
      chk("R3/R7/R8 hi_res", {17'd0, hi_res}, {17'd0, held_hi});
      chk("R4 hi_cout", {32'd0, hi_cout}, {32'd0, held_c});
      p2_v = p1_v; p2_s = p1_s;
      p1_v = v;
      if (v) begin
         ea = fa ? last_sum : a;   // R5
         eb = fb ? last_sum : b;   // R6
         p1_s = {1'b0, ea} + {1'b0, eb};
         last_sum = p1_s[31:0];
      end
      iss_vld = v; iss_a = a; iss_b = b; iss_fwd_a = fa; iss_fwd_b = fb;
   endtask

   task automatic flush();
      for (int i = 0; i < 3; i++) step(0, 32'hDEAD_BEEF, 32'h1234_5678, 1, 1);
   endtask

   task automatic t_reset();   // R1
      @(negedge clk);
      chk("R1 lo_vld", {32'd0, lo_vld}, 33'd0);
      chk("R1 hi_vld", {32'd0, hi_vld}, 33'd0);
      chk("R1 results", {hi_cout, hi_res, lo_res}, 33'd0);
      rst = 1'b0;
      flush();
   endtask

   task automatic t_single();  // R2 R3 R4 carry paths
      step(1, 32'h0000_FFFF, 32'h0000_0001, 0, 0);
      step(1, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0);
      step(1, 32'h8000_0000, 32'h8000_0000, 0, 0);
      step(1, 32'h1234_5678, 32'h0101_0101, 0, 0);
      flush();
   endtask

   task automatic t_chain_a(); // R5 R7 back-to-back
      step(1, 32'h0000_FFF0, 32'h0000_0008, 0, 0);
      for (int i = 0; i < 6; i++) step(1, 32'h0, 32'h0000_0007 + i, 1, 0);
      flush();
   endtask

   task automatic t_chain_b(); // R6 R7, both selects
      step(1, 32'h7FFF_8000, 32'h0000_8000, 0, 0);
      step(1, 32'h0001_0001, 32'h0, 0, 1);
      step(1, 32'h0, 32'h0, 1, 1);
      step(1, 32'hFFFF_0000, 32'h0, 0, 1);
      step(1, 32'h0, 32'h0, 1, 1);
      flush();
   endtask

   task automatic t_gap();     // R9 R8
      step(1, 32'h0001_FFFF, 32'h0000_0001, 0, 0);
      step(0, 32'h5555_5555, 32'h5555_5555, 0, 0);
      step(0, 32'hAAAA_AAAA, 32'h1111_1111, 1, 1);
      step(1, 32'h0, 32'hFFFF_FFFF, 1, 0);
      step(0, 32'h0, 32'h0, 0, 0);
      step(1, 32'h0000_0003, 32'h0, 0, 1);
      flush();
   endtask

   task automatic t_mixed();   // R7 mixed stream
      logic [31:0] x = 32'h1357_9BDF;
      for (int i = 0; i < 40; i++) begin
         x = x * 32'd1664525 + 32'd1013904223;
         step(x[3:0] != 4'd0, x ^ 32'hF0F0_0F0F, {x[15:0], x[31:16]},
              x[5], x[7]);
      end
      flush();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_single();
      t_chain_a();
      t_chain_b();
      t_gap();
      t_mixed();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule